// File: doc/BRIEF.md
# Paged-Register GPIO Controller with Edge Interrupts

This block controls 48 general-purpose pins, grouped as six 8-bit ports, through a small byte-wide register window on a simple synchronous bus. Each pin has an output latch that works open-drain: a latch bit of 1 pulls the pin low, and a latch bit of 0 releases it, so the pin can also serve as an input. Reading a port's data register returns the live pin levels after a two-flop synchroniser. Writing it loads the latch, unless that port's lock bit is set.

Pins on the first three ports can raise edge-triggered interrupts. Each such pin has a polarity bit, an enable bit and a captured-edge flag. The three per-port registers that hold them share one set of three addresses, and a 2-bit page field in the control register chooses which of them those addresses reach. The per-port pending bits, and the single interrupt output, follow the captured flags. Software acknowledges one pin by writing its enable bit to 0 and then back to 1. There is no separate acknowledge register.

The bus has no back-pressure. It accepts a read or a write on every cycle, and read data is valid on the cycle after the read strobe. Since nothing on the bus can stall, the block has no valid/ready pair at its edge.

Top module: `gpio_paged_irq`

## Requirements
- R1: After reset, all latches, locks, polarity, enable and flag bits are 0, the page field is 0, no pad is pulled low and `irq` is low.
- R2: A write to offset p (0–5) of an unlocked port loads that port's latch, and `pad_pull_low[8p+i]` equals latch bit i from the next cycle.
- R3: A read of offset p (0–5) returns the synchronised levels of pins 8p..8p+7, with bit i equal to pin 8p+i. `bus_rdata` is valid one cycle after `bus_rd`, and a pin change becomes visible after two clock edges.
- R4: Control register offset 7, bit p (p = 0–5) locks port p. A write to the data register of a locked port leaves its latch unchanged, while other ports still accept writes.
- R5: Offset 7 holds the page in bits 7:6 and the locks in bits 5:0, and reads back the value last written to it.
- R6: Offsets 8, 9 and 10 map to ports 0, 1 and 2. While the page is 0 they read as 0 and writes to them are ignored.
- R7: Page 1 holds polarity. A polarity bit of 1 captures a rising edge, and a polarity bit of 0 captures a falling edge. An edge of the other direction captures nothing.
- R8: A pin whose enable bit (page 2) is 0 captures no edge.
- R9: A captured flag (page 3, bit i = pin 8k+i) stays set until its enable bit is written to 0. Writing the enable back to 1 re-arms the pin, and the flags of other pins are untouched.
- R10: Offset 6 returns in bit k (k = 0–2) the OR of port k's captured flags. Bits 7:3 read as 0.
- R11: `irq` is high exactly while any captured flag is set.
- R12: Writes to the page-3 flag registers are ignored.
- R13: Edges on ports 3–5 never raise a pending bit or `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| pin_level | input | 48 | Pad levels as seen at the pins |
| pad_pull_low | output | 48 | Open-drain pull-down enable per pin |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench checks that each edge is captured only in the direction its polarity selects, and only when its enable is set. A swapped polarity sense would flag a pin on the wrong edge, and a missing enable gate would flag a disabled pin. It checks that an acknowledge of one pin, by writing its enable off and then on, clears only that pin's flag, so `irq` stays high while another flag remains set. It also checks that writes through the paged addresses are dropped on page 0 and on page 3, that a locked port keeps its latch, and that edges on the ports without interrupts never reach the pending register. A design that decoded the page field wrongly would show its error as a nonzero page-0 read or as a changed flag register.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int PAGE_W = 2;
  typedef enum logic [PAGE_W-1:0] {
    PG_NONE = 2'd0,
    PG_POL  = 2'd1,
    PG_EN   = 2'd2,
    PG_ID   = 2'd3
  } page_e;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode #(
  parameter int NUM_PORTS = 6,
  parameter int IRQ_PORTS = 3,
  parameter int ADDR_W    = 4
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_PORTS-1:0] data_sel,
  output logic                 pend_sel,
  output logic                 ctl_sel,
  output logic [IRQ_PORTS-1:0] paged_sel
);
  localparam int PEND_OFS  = NUM_PORTS;
  localparam int CTL_OFS   = NUM_PORTS + 1;
  localparam int PAGED_OFS = NUM_PORTS + 2;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_data
    assign data_sel[p] = (addr == ADDR_W'(p));
  end

  for (genvar k = 0; k < IRQ_PORTS; k++) begin : g_paged
    assign paged_sel[k] = (addr == ADDR_W'(PAGED_OFS + k));
  end

  assign pend_sel = (addr == ADDR_W'(PEND_OFS));
  assign ctl_sel  = (addr == ADDR_W'(CTL_OFS));
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank #(
  parameter int NUM_PORTS = 6,
  parameter int PORT_W    = 8,
  localparam int N_PINS   = NUM_PORTS * PORT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] wr_sel,
  input  logic [NUM_PORTS-1:0] lock,
  input  logic [PORT_W-1:0]    wdata,
  input  logic [N_PINS-1:0]    pin_level,
  output logic [N_PINS-1:0]    latch_q,
  output logic [N_PINS-1:0]    pin_sync
);
  logic [N_PINS-1:0] sync_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a   <= '0;
      pin_sync <= '0;
    end else begin
      sync_a   <= pin_level;
      pin_sync <= sync_a;
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        latch_q[p*PORT_W +: PORT_W] <= '0;
      else if (wr_sel[p] && !lock[p])
        latch_q[p*PORT_W +: PORT_W] <= wdata;
    end

    a_r4_locked_port_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel[p] && lock[p]) |=> $stable(latch_q[p*PORT_W +: PORT_W]));

    a_r2_open_port_loads: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel[p] && !lock[p]) |=> (latch_q[p*PORT_W +: PORT_W] == $past(wdata)));
  end
endmodule

// File: rtl/gpio_edge_unit.sv
module gpio_edge_unit #(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] pin_sync,
  input  logic              pol_wr,
  input  logic              en_wr,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] pol_q,
  output logic [PORT_W-1:0] en_q,
  output logic [PORT_W-1:0] id_q,
  output logic              pending
);
  logic [PORT_W-1:0] prev_q;
  logic [PORT_W-1:0] rise, fall, hit;

  assign rise = pin_sync & ~prev_q;
  assign fall = ~pin_sync & prev_q;
  assign hit  = (pol_q & rise) | (~pol_q & fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pol_q  <= '0;
      en_q   <= '0;
      id_q   <= '0;
    end else begin
      prev_q <= pin_sync;
      if (pol_wr) pol_q <= wdata;
      if (en_wr)  en_q  <= wdata;
      id_q <= (id_q | hit) & en_q;
    end
  end

  assign pending = |id_q;

  a_r9_flag_within_enable: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((id_q & ~$past(en_q)) == '0));

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(id_q & en_q) & ~id_q) == '0));

  a_r7_capture_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((id_q & ~$past(id_q) & ~$past(hit)) == '0));
endmodule

// File: rtl/gpio_paged_irq.sv
module gpio_paged_irq #(
  parameter int NUM_PORTS = 6,
  parameter int PORT_W    = 8,
  parameter int IRQ_PORTS = 3,
  parameter int ADDR_W    = 4,
  localparam int N_PINS   = NUM_PORTS * PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic [N_PINS-1:0] pin_level,
  output logic [N_PINS-1:0] pad_pull_low,
  output logic              irq
);
  import gpio_pkg::*;

  logic [NUM_PORTS-1:0] data_sel;
  logic                 pend_sel, ctl_sel;
  logic [IRQ_PORTS-1:0] paged_sel;
  logic [PORT_W-1:0]    ctl_q;
  page_e                page;
  logic [NUM_PORTS-1:0] lock;
  logic [N_PINS-1:0]    latch_q, pin_sync;
  logic [PORT_W-1:0]    pol_a [IRQ_PORTS];
  logic [PORT_W-1:0]    en_a  [IRQ_PORTS];
  logic [PORT_W-1:0]    id_a  [IRQ_PORTS];
  logic [IRQ_PORTS-1:0] pending;
  logic [PORT_W-1:0]    rd_mux;

  gpio_addr_decode #(
    .NUM_PORTS(NUM_PORTS), .IRQ_PORTS(IRQ_PORTS), .ADDR_W(ADDR_W)
  ) u_dec (
    .addr(bus_addr), .data_sel(data_sel), .pend_sel(pend_sel),
    .ctl_sel(ctl_sel), .paged_sel(paged_sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctl_q <= '0;
    else if (bus_wr && ctl_sel)
      ctl_q <= bus_wdata;
  end

  assign page = page_e'(ctl_q[PORT_W-1 -: PAGE_W]);
  assign lock = ctl_q[NUM_PORTS-1:0];

  gpio_port_bank #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_sel(data_sel & {NUM_PORTS{bus_wr}}),
    .lock(lock), .wdata(bus_wdata), .pin_level(pin_level),
    .latch_q(latch_q), .pin_sync(pin_sync)
  );

  assign pad_pull_low = latch_q;

  for (genvar k = 0; k < IRQ_PORTS; k++) begin : g_irq
    gpio_edge_unit #(.PORT_W(PORT_W)) u_edge (
      .clk(clk), .rst_n(rst_n),
      .pin_sync(pin_sync[k*PORT_W +: PORT_W]),
      .pol_wr(bus_wr && paged_sel[k] && (page == PG_POL)),
      .en_wr(bus_wr && paged_sel[k] && (page == PG_EN)),
      .wdata(bus_wdata),
      .pol_q(pol_a[k]), .en_q(en_a[k]), .id_q(id_a[k]),
      .pending(pending[k])
    );
  end

  assign irq = |pending;

  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (data_sel[p]) rd_mux = pin_sync[p*PORT_W +: PORT_W];
    if (pend_sel) rd_mux[IRQ_PORTS-1:0] = pending;
    if (ctl_sel)  rd_mux = ctl_q;
    for (int k = 0; k < IRQ_PORTS; k++) begin
      if (paged_sel[k]) begin
        case (page)
          PG_POL:  rd_mux = pol_a[k];
          PG_EN:   rd_mux = en_a[k];
          PG_ID:   rd_mux = id_a[k];
          default: rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= rd_mux;
  end

  initial begin
    a_r5_lock_field_fits: assert (NUM_PORTS <= PORT_W - gpio_pkg::PAGE_W);
  end

  a_r6_page0_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (|paged_sel) && (page == PG_NONE)) |=> (bus_rdata == '0));

  a_r10_pend_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && pend_sel) |=> (bus_rdata[PORT_W-1:IRQ_PORTS] == '0));

  a_r11_irq_low_without_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (pending == '0) |-> !irq);
endmodule

// File: tb/tb_gpio_paged_irq.sv
module tb_gpio_paged_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [47:0] ext_lvl = {48{1'b1}};
  logic [47:0] pin_level, pad_pull_low;
  logic        irq;

  int n_cmp = 0, n_bad = 0;
  int cycles = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;

  always #10 clk = ~clk;

  assign pin_level = ext_lvl & ~pad_pull_low;

  gpio_paged_irq dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_level(pin_level), .pad_pull_low(pad_pull_low), .irq(irq)
  );

  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (bus_rdata !== e) begin
        n_bad++;
        $display("FAIL %s: rdata=%02h expected=%02h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk(input logic [63:0] act, input logic [63:0] e, input string t);
    n_cmp++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", t, act, e);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected<20000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(3);
    // R1 reset state
    chk(64'(pad_pull_low), 64'h0, "R1 pads released");
    chk(64'(irq), 64'h0, "R1 irq low");
    rd(4'd7, 8'h00, "R1 control reg zero");
    rd(4'd0, 8'hFF, "R3 port0 idle high");
    // R2 / R3 latch and readback
    wr(4'd1, 8'h0F);
    chk(64'(pad_pull_low[15:8]), 64'h0F, "R2 port1 pull-down");
    idle(3);
    rd(4'd1, 8'hF0, "R3 port1 reads inverse of latch");
    ext_lvl[39:32] = 8'h3C;
    idle(3);
    rd(4'd4, 8'h3C, "R3 port4 external levels");
    // R4 / R5 locks
    wr(4'd7, 8'h02);
    rd(4'd7, 8'h02, "R5 control readback");
    wr(4'd1, 8'hFF);
    chk(64'(pad_pull_low[15:8]), 64'h0F, "R4 locked port holds");
    wr(4'd2, 8'h01);
    chk(64'(pad_pull_low[23:16]), 64'h01, "R4 unlocked port writes");
    wr(4'd2, 8'h00);
    wr(4'd7, 8'h00);
    // R6 page 0
    wr(4'd7, 8'h80);
    wr(4'd8, 8'h05);
    wr(4'd7, 8'h00);
    rd(4'd8, 8'h00, "R6 page0 read zero");
    wr(4'd8, 8'hFF);
    wr(4'd7, 8'h80);
    rd(4'd8, 8'h05, "R6 page0 write ignored");
    // R7..R12 interrupts on port 0
    wr(4'd7, 8'h40);
    wr(4'd8, 8'h01);
    rd(4'd8, 8'h01, "R7 polarity readback");
    wr(4'd7, 8'h80);
    wr(4'd8, 8'h03);
    wr(4'd7, 8'hC0);
    ext_lvl[0] = 1'b0;
    idle(4);
    chk(64'(irq), 64'h0, "R7 falling edge ignored with rising polarity");
    ext_lvl[0] = 1'b1;
    idle(4);
    chk(64'(irq), 64'h1, "R11 irq on rising capture");
    rd(4'd8, 8'h01, "R7 line0 flag");
    rd(4'd6, 8'h01, "R10 port0 pending");
    ext_lvl[1] = 1'b0;
    idle(4);
    rd(4'd8, 8'h03, "R7 falling capture line1");
    ext_lvl[2] = 1'b0;
    idle(4);
    rd(4'd8, 8'h03, "R8 disabled line2 not captured");
    wr(4'd8, 8'h00);
    rd(4'd8, 8'h03, "R12 flag register read-only");
    wr(4'd7, 8'h80);
    wr(4'd8, 8'h02);
    wr(4'd8, 8'h03);
    wr(4'd7, 8'hC0);
    rd(4'd8, 8'h02, "R9 ack clears only line0");
    chk(64'(irq), 64'h1, "R11 irq held by line1");
    wr(4'd7, 8'h80);
    wr(4'd8, 8'h01);
    wr(4'd8, 8'h03);
    wr(4'd7, 8'hC0);
    rd(4'd8, 8'h00, "R9 ack clears line1");
    rd(4'd6, 8'h00, "R10 pending clear");
    chk(64'(irq), 64'h0, "R11 irq released");
    // port 2 line 23
    wr(4'd7, 8'h40);
    wr(4'd10, 8'h80);
    wr(4'd7, 8'h80);
    wr(4'd10, 8'h80);
    wr(4'd7, 8'hC0);
    ext_lvl[23] = 1'b0;
    idle(4);
    ext_lvl[23] = 1'b1;
    idle(4);
    rd(4'd10, 8'h80, "R7 port2 line7 rising capture");
    rd(4'd6, 8'h04, "R10 port2 pending bit");
    wr(4'd7, 8'h80);
    wr(4'd10, 8'h00);
    wr(4'd10, 8'h80);
    wr(4'd7, 8'hC0);
    chk(64'(irq), 64'h0, "R9 port2 ack");
    // R13 ports 3-5
    ext_lvl[24] = 1'b0;
    ext_lvl[47] = 1'b0;
    idle(4);
    ext_lvl[24] = 1'b1;
    ext_lvl[47] = 1'b1;
    idle(4);
    chk(64'(irq), 64'h0, "R13 port3/5 edges no irq");
    rd(4'd6, 8'h00, "R13 no pending from upper ports");
    idle(3);
    finish_run();
  end
endmodule